// File: doc/BRIEF.md
# Cascaded Programmable Clock Divider

The block divides a single input clock by a programmable integer ratio. The ratio is made up of several four-bit down-counting digits that all run on the same clock. Digit 0 counts on every cycle while the chain is running. A higher digit moves down by one only when every digit below it reads zero, so a digit borrows from the one above it when it wraps. When the whole chain holds the value one, every digit reloads its nibble of the preset on that clock edge. A registered output marks that reload. The output therefore carries one single-cycle pulse every N input cycles, and no combinational terminal-count glitch can reach it.

A small controller sequences the chain through three states. LOAD is entered from reset and loads the preset. COUNT runs the digits and reloads them whenever the chain reaches one. HALT holds the output high while the preset is zero. The transitions are:
- LOAD→COUNT when the preset is nonzero.
- LOAD→HALT when the preset is zero.
- COUNT→COUNT (a reload) when the chain reaches one and the preset is nonzero.
- COUNT→HALT when the chain reaches one and the preset is zero.
- HALT→LOAD when the preset becomes nonzero.

The preset is sampled only at load and reload edges, so a new ratio takes effect from the next period.

Top module: `casc_divider`

## Requirements
- R1: The ratio N is the preset vector read as an unsigned integer: stage i holds bits [4i+3:4i] and carries weight 16^i. For N of 2 or more, rising edges of `div_out` are exactly N clock cycles apart.
- R2: For N of 2 or more, each pulse on `div_out` is exactly one clock cycle wide.
- R3: While the ratio is zero, `div_out` stays constantly high. This applies after reset, and also from the first reload after a running divider is given a zero preset.
- R4: With N equal to 1, `div_out` is high in every cycle.
- R5: While `rst` is high, `div_out` is low. The first pulse after reset release appears right after the (N+1)th rising clock edge.
- R6: A preset change made during a period does not shorten or lengthen that period. The new ratio applies from the period that begins at the next reload.
- R7: When the preset leaves zero, `div_out` goes low at the next edge. It then pulses with the new period N.
- R8: Each digit moves down by one only on the edges where all lower digits read zero. It wraps from 0 to 15 on those edges, so the chain counts in plain binary across stage boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ratio | input | 4*STAGES | Division ratio, one nibble per stage, stage 0 in the low nibble |
| div_out | output | 1 | Registered divided output: one-cycle pulse per period, held high for ratio zero |

## Verification
The assertions take for granted that `rst` is synchronous and held for at least one edge. They also assume that `ratio` changes only between edges and not as a function of the outputs. The bench therefore drives `ratio` and `rst` only on falling clock edges. It samples `div_out` on falling edges as well, so each measured interval counts whole cycles. Period measurements start only after the first pulse following a reset or a ratio change, and they keep the latency and hand-over cases as separate checks.

// File: rtl/casc_div_pkg.sv
package casc_div_pkg;

    localparam int DIGIT_W = 4;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_COUNT = 2'd1,
        ST_HALT  = 2'd2
    } div_state_e;

endpackage

// File: rtl/casc_digit.sv
module casc_digit #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         dec_en,
    input  logic [W-1:0] seed,
    output logic [W-1:0] value,
    output logic         is_zero
);

    logic [W-1:0] value_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
        end else if (load) begin
            value_q <= seed;
        end else if (dec_en) begin
            value_q <= value_q - W'(1);
        end
    end

    assign value   = value_q;
    assign is_zero = (value_q == '0);

    // R8
    digit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_en && !load) |=> (value_q == W'($past(value_q) - W'(1))));

    // R8
    digit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!dec_en && !load) |=> $stable(value_q));

endmodule

// File: rtl/casc_ctrl.sv
module casc_ctrl
    import casc_div_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ratio_zero,
    input  logic chain_one,
    output logic load_o,
    output logic run_o,
    output logic pulse_o
);

    div_state_e state_q, state_d;
    logic       pulse_q;

    always_comb begin
        state_d = state_q;
        load_o  = 1'b0;
        run_o   = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                if (ratio_zero) begin
                    state_d = ST_HALT;
                end else begin
                    load_o  = 1'b1;
                    state_d = ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (chain_one) begin
                    if (ratio_zero) begin
                        state_d = ST_HALT;
                    end else begin
                        load_o = 1'b1;
                    end
                end else begin
                    run_o = 1'b1;
                end
            end
            ST_HALT: begin
                if (!ratio_zero) begin
                    state_d = ST_LOAD;
                end
            end
            default: state_d = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= ((state_q == ST_COUNT) && chain_one) || (state_d == ST_HALT);
        end
    end

    assign pulse_o = pulse_q;

    // R3
    halt_high_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HALT) |-> pulse_q);

    // R1
    reload_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COUNT && chain_one) |=> pulse_q);

    // R7
    wake_low_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HALT && !ratio_zero) |=> !pulse_q);

endmodule

// File: rtl/casc_divider.sv
module casc_divider
    import casc_div_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [STAGES*DIGIT_W-1:0]   ratio,
    output logic                        div_out
);

    localparam int VW = STAGES * DIGIT_W;

    logic [VW-1:0]     chain_val;
    logic [STAGES-1:0] dig_zero;
    logic [STAGES:0]   dig_en;
    logic [STAGES:0]   upper_zero;
    logic              load_w;
    logic              run_w;
    logic              chain_one;
    logic              ratio_zero;

    assign dig_en[0] = run_w;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_digit
            casc_digit #(.W(DIGIT_W)) u_digit (
                .clk     (clk),
                .rst     (rst),
                .load    (load_w),
                .dec_en  (dig_en[gi]),
                .seed    (ratio[gi*DIGIT_W +: DIGIT_W]),
                .value   (chain_val[gi*DIGIT_W +: DIGIT_W]),
                .is_zero (dig_zero[gi])
            );
            assign dig_en[gi+1] = dig_en[gi] & dig_zero[gi];
        end
    endgenerate

    // upper_zero[i]: all digits at index i and above read zero
    assign upper_zero[STAGES] = 1'b1;
    generate
        for (gi = STAGES - 1; gi >= 0; gi--) begin : g_upper
            assign upper_zero[gi] = upper_zero[gi+1] & dig_zero[gi];
        end
    endgenerate

    assign chain_one  = (chain_val[DIGIT_W-1:0] == DIGIT_W'(1)) && upper_zero[1];
    assign ratio_zero = (ratio == '0);

    casc_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ratio_zero (ratio_zero),
        .chain_one  (chain_one),
        .load_o     (load_w),
        .run_o      (run_w),
        .pulse_o    (div_out)
    );

    // R1
    reload_value_chk: assert property (@(posedge clk) disable iff (rst)
        load_w |=> (chain_val == $past(ratio)));

    // R8
    carry_chain_chk: assert property (@(posedge clk) disable iff (rst)
        (run_w && !load_w && chain_val != '0) |=> (chain_val == VW'($past(chain_val) - VW'(1))));

endmodule

// File: tb/sim_casc_divider.sv
module sim_casc_divider;

    localparam int STAGES = 3;
    localparam int VW     = STAGES * 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [VW-1:0] ratio = '0;
    logic          div_out;

    int n_cmp  = 0;
    int n_bad  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    casc_divider #(.STAGES(STAGES)) u0 (
        .clk     (clk),
        .rst     (rst),
        .ratio   (ratio),
        .div_out (div_out)
    );

    always @(posedge clk) cycles <= cycles + 1;

    initial begin
        wait (cycles >= 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles, expected < 150000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [VW-1:0] r);
        @(negedge clk);
        rst   = 1'b1;
        ratio = r;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // waits on falling edges until div_out is high; returns samples taken
    task automatic wait_high(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!div_out && n < 3000);
    endtask

    // from a high sample, counts samples to the next high one; reports width
    task automatic next_interval(output int n, output int width_low);
        n = 0;
        width_low = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) width_low = !div_out;
        end while (!div_out && n < 3000);
    endtask

    task automatic t_reset_latency();
        int n;
        @(negedge clk);
        rst   = 1'b1;
        ratio = 12'h005;
        repeat (3) @(negedge clk);
        check("R5 low in reset", int'(div_out), 0);
        rst = 1'b0;
        wait_high(n);
        check("R5 first pulse latency", n, 6);
    endtask

    task automatic t_period(input logic [VW-1:0] r);
        int n, w, dummy;
        do_reset(r);
        wait_high(dummy);
        for (int k = 0; k < 3; k++) begin
            next_interval(n, w);
            check("R1 period", n, int'(r));
            if (k == 0) check("R2 one-cycle width", w, 1);
        end
    endtask

    task automatic t_one();
        int highs = 0, dummy;
        do_reset(12'h001);
        wait_high(dummy);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            highs += int'(div_out);
        end
        check("R4 ratio one always high", highs, 12);
    endtask

    task automatic t_zero();
        int highs = 0;
        do_reset(12'h000);
        @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            highs += int'(div_out);
        end
        check("R3 zero after reset held high", highs, 20);
        do_reset(12'h007);
        repeat (12) @(negedge clk);
        ratio = 12'h000;
        repeat (10) @(negedge clk);
        highs = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            highs += int'(div_out);
        end
        check("R3 zero while running held high", highs, 20);
    endtask

    task automatic t_change();
        int n, w, dummy;
        do_reset(12'h00A);
        wait_high(dummy);
        next_interval(n, w);
        ratio = 12'h003;
        next_interval(n, w);
        check("R6 current period keeps old ratio", n, 10);
        next_interval(n, w);
        check("R6 new ratio from next reload", n, 3);
    endtask

    task automatic t_wake();
        int n, w, dummy;
        do_reset(12'h000);
        repeat (4) @(negedge clk);
        ratio = 12'h004;
        @(negedge clk);
        check("R7 low after leaving zero", int'(div_out), 0);
        wait_high(dummy);
        next_interval(n, w);
        check("R7 period after wake", n, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_latency();
        t_period(12'h005);
        t_period(12'h00F);
        t_period(12'h010);  // R8 borrow across stage 0/1
        t_period(12'h100);  // R8 borrow across two stages
        t_period(12'h123);
        t_period(12'h201);
        t_period(12'h002);
        t_one();
        t_zero();
        t_change();
        t_wake();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule